// File: doc/BRIEF.md
# Half-Duplex Line Arbiter

This block joins a host-side serial data line and a card-side serial data line that share one half-duplex conversation. Each side is an open-drain style port. The block sees the line level through an input, pulls the line low through an output-low enable, and speeds up a release through a strong pull-up enable. No pin sets the direction. The side whose line drops first becomes the master, and the block copies that low onto the other side. It keeps that ownership until both lines read high again. Each time it lets go of a line it was holding low, it fires a strong pull-up pulse of fixed length on that line.

An enable from the power-up sequencer gates all of this. While the enable is low, the card line is held low and the host line is left free, so the host's pull-up keeps it high. The two line inputs pass through two-flop synchronizers before any decision is made. A change on a line therefore reaches the opposite drive output after at most three clock edges. There is no data stream with a handshake here: the lines are plain level signals.

Top module: `duplex_line_arbiter`

## Requirements
- R1: While `en` is 0, `card_pull_low` is 1, `host_pull_low` is 0 and both boost outputs are 0, whatever either line does.
- R2: While `en` is 1 and both lines read high, neither pull-low output is asserted.
- R3: When enabled and idle, a low on the host line is copied onto the card line (`card_pull_low`=1) within three clock edges. It is released within two edges after the host line goes high again. `host_pull_low` stays 0 while the host is master.
- R4: When enabled and idle, a low on the card line is copied onto the host line (`host_pull_low`=1) in the same way. `card_pull_low` stays 0 while the card is master.
- R5: If both lines fall in the same cycle from idle, the host side becomes master.
- R6: Ownership returns to idle only when both synchronized lines read high. A line that is still low while the master has already released never seizes ownership.
- R7: When a pull-low output falls while enabled, the boost output on that side is 1 for exactly `BOOST_CYC` consecutive cycles, starting one cycle after the release. Boost is never 1 while that side's pull-low is 1 or while `en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable from the power sequencer |
| host_line | input | 1 | Host-side line level |
| host_pull_low | output | 1 | Pull host line low |
| host_boost | output | 1 | Strong pull-up on host line |
| card_line | input | 1 | Card-side line level |
| card_pull_low | output | 1 | Pull card line low |
| card_boost | output | 1 | Strong pull-up on card line |

## Verification
The checker enforces the following on every cycle:
- the disabled output state;
- that both sides are never pulled low together;
- that a side is pulled low only when the opposite line read low two edges earlier;
- that a boost begins only after its pull-low was released.

Only the bench scenarios can show that whole bytes pass correctly in each direction. The same goes for the host winning a simultaneous fall, a lingering card low not stealing ownership, and the exact boost width.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_CARD = 2'd2
  } owner_t;

  localparam int SIDE_HOST = 0;
  localparam int SIDE_CARD = 1;
  localparam int NUM_SIDES = 2;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/owner_fsm.sv
module owner_fsm
  import arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   host_hi,
  input  logic   card_hi,
  output owner_t owner
);
  owner_t nxt;

  always_comb begin
    nxt = owner;
    if (!en) begin
      nxt = OWN_IDLE;
    end else begin
      unique case (owner)
        OWN_IDLE: begin
          if (!host_hi)      nxt = OWN_HOST;
          else if (!card_hi) nxt = OWN_CARD;
        end
        OWN_HOST, OWN_CARD: begin
          if (host_hi && card_hi) nxt = OWN_IDLE;
        end
        default: nxt = OWN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWN_IDLE;
    else        owner <= nxt;
  end
endmodule

// File: rtl/boost_pulse.sv
module boost_pulse #(
  parameter int BOOST_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pull_low,
  output logic boost
);
  localparam int CNT_W = $clog2(BOOST_CYC + 1);

  logic             was_low;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_low <= 1'b0;
      left    <= '0;
    end else begin
      was_low <= pull_low;
      if (!en || pull_low)     left <= '0;
      else if (was_low)        left <= CNT_W'(BOOST_CYC);
      else if (left != '0)     left <= left - CNT_W'(1);
    end
  end

  assign boost = (left != '0) && !pull_low && en;
endmodule

// File: rtl/duplex_line_arbiter.sv
module duplex_line_arbiter
  import arb_pkg::*;
#(
  parameter int BOOST_CYC   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic host_line,
  output logic host_pull_low,
  output logic host_boost,
  input  logic card_line,
  output logic card_pull_low,
  output logic card_boost
);
  logic [NUM_SIDES-1:0] raw_in;
  logic [NUM_SIDES-1:0] hi_s;
  logic [NUM_SIDES-1:0] pull;
  logic [NUM_SIDES-1:0] bst;
  owner_t               owner;

  assign raw_in[SIDE_HOST] = host_line;
  assign raw_in[SIDE_CARD] = card_line;

  owner_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .host_hi (hi_s[SIDE_HOST]),
    .card_hi (hi_s[SIDE_CARD]),
    .owner   (owner)
  );

  // A side is pulled low while the opposite side owns the line and reads low.
  assign pull[SIDE_HOST] = en && (owner == OWN_CARD) && !hi_s[SIDE_CARD];
  assign pull[SIDE_CARD] = !en || ((owner == OWN_HOST) && !hi_s[SIDE_HOST]);

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in[s]),
      .q     (hi_s[s])
    );
    boost_pulse #(.BOOST_CYC(BOOST_CYC)) u_boost (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .pull_low (pull[s]),
      .boost    (bst[s])
    );
  end

  assign host_pull_low = pull[SIDE_HOST];
  assign card_pull_low = pull[SIDE_CARD];
  assign host_boost    = bst[SIDE_HOST];
  assign card_boost    = bst[SIDE_CARD];
endmodule

// File: rtl/duplex_line_arbiter_chk.sv
module duplex_line_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic host_line,
  input logic card_line,
  input logic host_pull_low,
  input logic card_pull_low,
  input logic host_boost,
  input logic card_boost
);
  // R1
  disabled_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (card_pull_low && !host_pull_low && !host_boost && !card_boost));

  // R6
  single_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pull_low && card_pull_low));

  // R3
  card_echo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(en, 2) && card_pull_low) |-> !$past(host_line, 2));

  // R4
  host_echo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_pull_low |-> !$past(card_line, 2));

  // R7
  card_boost_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_boost) |-> $past(card_pull_low, 2));

  // R7
  host_boost_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_boost) |-> $past(host_pull_low, 2));
endmodule

bind duplex_line_arbiter duplex_line_arbiter_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en            (en),
  .host_line     (host_line),
  .card_line     (card_line),
  .host_pull_low (host_pull_low),
  .card_pull_low (card_pull_low),
  .host_boost    (host_boost),
  .card_boost    (card_boost)
);

// File: tb/duplex_line_arbiter_test.sv
module duplex_line_arbiter_test;
  localparam int BC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic host_tx = 1'b1;
  logic card_tx = 1'b1;
  logic host_pull_low, host_boost, card_pull_low, card_boost;
  logic host_wire, card_wire;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Open-drain wired lines: low if either party pulls low.
  assign host_wire = host_tx && !host_pull_low;
  assign card_wire = card_tx && !card_pull_low;

  always #5 clk = ~clk;

  duplex_line_arbiter #(.BOOST_CYC(BC)) uut (
    .clk (clk), .rst_n (rst_n), .en (en),
    .host_line (host_wire), .host_pull_low (host_pull_low), .host_boost (host_boost),
    .card_line (card_wire), .card_pull_low (card_pull_low), .card_boost (card_boost)
  );

  // Boost run-length and misuse monitors.
  int run_c = 0, last_c = 0, run_h = 0, last_h = 0;
  int boost_misuse = 0;
  bit host_master_phase = 0, card_master_phase = 0;
  int wrong_side = 0;

  always @(negedge clk) begin
    if (card_boost) run_c++; else if (run_c != 0) begin last_c = run_c; run_c = 0; end
    if (host_boost) run_h++; else if (run_h != 0) begin last_h = run_h; run_h = 0; end
    if ((card_boost && (card_pull_low || !en)) || (host_boost && (host_pull_low || !en)))
      boost_misuse++;
    if (host_master_phase && host_pull_low) wrong_side++;
    if (card_master_phase && card_pull_low) wrong_side++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_byte(input logic [7:0] b);
    logic [7:0] rx;
    for (int i = 7; i >= 0; i--) begin
      host_tx = b[i];
      wait_n(6);
      rx[i] = card_wire;
      wait_n(4);
    end
    host_tx = 1'b1;
    wait_n(6);
    check("R3 host to card byte", rx, b);
  endtask

  task automatic card_byte(input logic [7:0] b);
    logic [7:0] rx;
    for (int i = 7; i >= 0; i--) begin
      card_tx = b[i];
      wait_n(6);
      rx[i] = host_wire;
      wait_n(4);
    end
    card_tx = 1'b1;
    wait_n(6);
    check("R4 card to host byte", rx, b);
  endtask

  initial begin
    wait_n(3);
    // Reset state with enable low (R1)
    check("R1 reset card pulled low", card_pull_low, 1);
    check("R1 reset host free", host_pull_low, 0);
    rst_n = 1'b1;
    wait_n(3);

    // R1: disabled, host toggles; card stays low, host reads its own level
    for (int k = 0; k < 16; k++) begin
      host_tx = k[0];
      card_tx = k[1];
      wait_n(4);
      check("R1 disabled card line low", card_wire, 0);
      check("R1 disabled host line follows host", host_wire, k[0]);
      check("R1 disabled no boost", host_boost | card_boost, 0);
    end
    host_tx = 1'b1; card_tx = 1'b1;

    en = 1'b1;
    wait_n(8);
    check("R7 enable release boost width", last_c, BC);
    check("R2 idle no host pull", host_pull_low, 0);
    check("R2 idle no card pull", card_pull_low, 0);

    // R7: boost width on card side after host-mastered low
    host_master_phase = 1;
    host_tx = 1'b0; wait_n(10);
    host_tx = 1'b1; wait_n(10);
    check("R7 card boost width", last_c, BC);

    // R3: every byte host to card
    for (int v = 0; v < 256; v++) host_byte(8'(v));
    host_master_phase = 0;
    check("R3 host never pulled while host master", wrong_side, 0);

    // R7: boost width on host side
    card_master_phase = 1;
    card_tx = 1'b0; wait_n(10);
    card_tx = 1'b1; wait_n(10);
    check("R7 host boost width", last_h, BC);

    // R4: every byte card to host
    for (int v = 0; v < 256; v++) card_byte(8'(v));
    card_master_phase = 0;
    check("R4 card never pulled while card master", wrong_side, 0);

    // R5: simultaneous fall, host wins
    host_tx = 1'b0; card_tx = 1'b0;
    wait_n(6);
    check("R5 tie gives host: card pulled", card_pull_low, 1);
    check("R5 tie gives host: host free", host_pull_low, 0);

    // R6: host releases while card still low on its own; no flip
    host_tx = 1'b1;
    for (int k = 0; k < 8; k++) begin
      wait_n(1);
      if (k >= 3) check("R6 lingering card low does not take over", host_pull_low, 0);
    end
    check("R6 card released after host rise", card_pull_low, 0);
    card_tx = 1'b1;
    wait_n(6);
    check("R2 idle after both high host", host_pull_low, 0);
    check("R2 idle after both high card", card_pull_low, 0);
    card_tx = 1'b0;
    wait_n(6);
    check("R6 idle regained, card can own", host_pull_low, 1);
    card_tx = 1'b1;
    wait_n(10);

    // R1: disable mid-transfer
    host_tx = 1'b0;
    wait_n(6);
    en = 1'b0;
    wait_n(2);
    check("R1 disable forces card low", card_wire, 0);
    check("R1 disable frees host", host_pull_low, 0);
    host_tx = 1'b1;
    wait_n(4);

    check("R7 boost never overlaps pull or disable", boost_misuse, 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule